// File: doc/BRIEF.md
# Halfword zero-extending load unit

This execution unit serves a 64-bit big-endian core. It accepts one 32-bit instruction word at a time and recognises four loads of an unsigned 16-bit quantity: base plus displacement, base plus displacement with update, base plus index, and base plus index with update. It drives the register numbers it needs onto two combinational register read ports and forms a 32-bit effective address. It fetches the two bytes one at a time over a byte-wide request/response memory port. It then writes the zero-extended halfword into the destination register. For the update forms, a second write, one cycle later, stores the effective address into the base register.

While an instruction is in flight the unit holds its input ready low, so it works on exactly one instruction at a time. An update form whose base field is 0, or whose base field equals the destination field, is an invalid form. The unit still executes it and raises an indicator together with the destination write. A word that matches none of the four encodings produces a one-cycle flag and has no other effect.

Top module: `half_zload_unit`

## Requirements
- R1: With bit 31 of `in_instr` as the most significant bit, `in_instr[31:26]` is the primary opcode, `[25:21]` the destination field, `[20:16]` field A, `[15:0]` the displacement, `[15:11]` field B and `[10:1]` the extended opcode. Bit 0 is ignored. Primary opcode 40 selects the displacement load and 41 the displacement load with update. Primary opcode 31 with extended opcode 279 selects the indexed load, and with 311 the indexed load with update.
- R2: Any other word raises `flag_unknown` for exactly one cycle, issues no memory request and no write-back, and the unit then returns to ready.
- R3: In the two non-update forms, an A field of 0 uses a base of literal zero and not the content of register 0. The update forms always use the register named by A, including register 0.
- R4: The effective address is the low 32 bits of the wrapping 64-bit sum of the base and either the sign-extended displacement or the full 64-bit register B value.
- R5: Exactly two byte requests are issued, first at the effective address and then at the effective address plus one (modulo 2^32), for any alignment.
- R6: The destination write carries `{48'b0, byte(EA), byte(EA+1)}`.
- R7: A non-update form performs a single write-back, to the destination. An update form performs the destination write and, in the next cycle, a write of the zero-extended effective address to register A, so when A equals the destination the effective address is written last.
- R8: `flag_bad_form` is high in the destination-write cycle of an update form whose A field is 0 or equals the destination field, and low in all other cycles. Such an instruction is still fully executed.
- R9: `in_ready` is low from the cycle after acceptance until the last write-back is done, and an `in_valid` held during that time is ignored. A request that is not accepted keeps `mem_req_valid` high and `mem_req_addr` stable.
- R10: Synchronous reset returns the unit to idle, with `in_ready` high and no memory request, write-back or flag, even when an instruction is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit idle and able to take a word |
| in_instr | input | 32 | Instruction word |
| rd_a_idx | output | 5 | Register number for read port A |
| rd_a_data | input | 64 | Value of register `rd_a_idx`, same cycle |
| rd_b_idx | output | 5 | Register number for read port B |
| rd_b_data | input | 64 | Value of register `rd_b_idx`, same cycle |
| mem_req_valid | output | 1 | Byte read request pending |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_rsp_valid | input | 1 | Returned byte valid |
| mem_rsp_data | input | 8 | Returned byte |
| wb_en | output | 1 | Register write this cycle |
| wb_idx | output | 5 | Register number written |
| wb_data | output | 64 | Value written |
| flag_bad_form | output | 1 | Invalid update form, with the destination write |
| flag_unknown | output | 1 | Unrecognised instruction word, one-cycle pulse |

## Verification
The hardest case to reach from the ports is an update form whose base and destination name the same register while the memory stalls. Both writes then target one register, and only their order shows that the address wins. The bench sweeps every A field across all four forms, adds explicit A-equals-destination and A-equals-zero update cases, and varies the request stall and response latency per instruction. It also presets the base registers to values near the 32-bit boundary, so that the effective address is 0xFFFFFFFF and the second byte wraps to address zero. Mistakes in truncation or carry then show up in the logged request addresses.

// File: rtl/hzl_pkg.sv
package hzl_pkg;

   localparam int FLD_W  = 5;
   localparam int DISP_W = 16;

   typedef struct packed {
      logic              known;
      logic              indexed;
      logic              update;
      logic [FLD_W-1:0]  rt;
      logic [FLD_W-1:0]  ra;
      logic [FLD_W-1:0]  rb;
      logic [DISP_W-1:0] disp;
   } hzl_op_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_REQ,
      ST_WAIT,
      ST_WB_DST,
      ST_WB_BASE
   } hzl_state_t;

endpackage

// File: rtl/hzl_decode.sv
module hzl_decode
   import hzl_pkg::*;
#(
   parameter int INSTR_W     = 32,
   parameter int OPC_DISP    = 40,
   parameter int OPC_DISPUPD = 41,
   parameter int OPC_EXT     = 31,
   parameter int XO_IDX      = 279,
   parameter int XO_IDXUPD   = 311
) (
   input  logic [INSTR_W-1:0] instr,
   output hzl_op_t            op
);
   localparam int OPC_W   = 6;
   localparam int XO_W    = 10;
   localparam int OPC_LSB = INSTR_W - OPC_W;
   localparam int RT_LSB  = OPC_LSB - FLD_W;
   localparam int RA_LSB  = RT_LSB - FLD_W;
   localparam int RB_LSB  = RA_LSB - FLD_W;
   localparam int XO_LSB  = 1;

   if (INSTR_W != 32) begin : g_bad_width
      $error("hzl_decode: instruction word must be 32 bits");
   end
   if (OPC_DISP >= (1 << OPC_W) || OPC_DISPUPD >= (1 << OPC_W) ||
       OPC_EXT >= (1 << OPC_W)) begin : g_bad_opc
      $error("hzl_decode: primary opcode out of range");
   end
   if (XO_IDX >= (1 << XO_W) || XO_IDXUPD >= (1 << XO_W)) begin : g_bad_xo
      $error("hzl_decode: extended opcode out of range");
   end

   logic [OPC_W-1:0] opc;
   logic [XO_W-1:0]  xo;
   logic             is_d, is_du, is_x, is_xu;

   always_comb begin
      opc   = instr[INSTR_W-1:OPC_LSB];
      xo    = instr[XO_LSB+XO_W-1:XO_LSB];
      is_d  = (opc == OPC_W'(OPC_DISP));
      is_du = (opc == OPC_W'(OPC_DISPUPD));
      is_x  = (opc == OPC_W'(OPC_EXT)) && (xo == XO_W'(XO_IDX));
      is_xu = (opc == OPC_W'(OPC_EXT)) && (xo == XO_W'(XO_IDXUPD));

      op.known   = is_d | is_du | is_x | is_xu;
      op.indexed = is_x | is_xu;
      op.update  = is_du | is_xu;
      op.rt      = instr[RT_LSB+FLD_W-1:RT_LSB];
      op.ra      = instr[RA_LSB+FLD_W-1:RA_LSB];
      op.rb      = instr[RB_LSB+FLD_W-1:RB_LSB];
      op.disp    = instr[DISP_W-1:0];
   end
endmodule

// File: rtl/hzl_agen.sv
module hzl_agen
   import hzl_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int ADDR_W = 32
) (
   input  logic              base_zero,
   input  logic              indexed,
   input  logic [DISP_W-1:0] disp,
   input  logic [XLEN-1:0]   a_data,
   input  logic [XLEN-1:0]   b_data,
   output logic [ADDR_W-1:0] ea
);
   logic [XLEN-1:0] base, offs, sum;

   always_comb begin
      base = base_zero ? '0 : a_data;
      offs = indexed ? b_data : {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
      sum  = base + offs;
   end

   if (ADDR_W == XLEN) begin : g_full
      assign ea = sum;
   end else begin : g_trunc
      assign ea = sum[ADDR_W-1:0];
   end
endmodule

// File: rtl/hzl_seq.sv
module hzl_seq
   import hzl_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int ADDR_W = 32,
   parameter int NBYTES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  hzl_op_t           dec_op,
   output hzl_op_t           op_q,
   input  logic [ADDR_W-1:0] ea_in,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [7:0]        mem_rsp_data,
   output logic              wb_en,
   output logic [FLD_W-1:0]  wb_idx,
   output logic [XLEN-1:0]   wb_data,
   output logic              flag_bad_form,
   output logic              flag_unknown
);
   localparam int ACC_W  = 8 * NBYTES;
   localparam int BCNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   hzl_state_t        state;
   logic [ADDR_W-1:0] ea_q;
   logic [ACC_W-1:0]  acc;
   logic [BCNT_W-1:0] bcnt;
   logic [XLEN-1:0]   ea_ext;
   logic              last_byte;

   assign last_byte = (bcnt == BCNT_W'(NBYTES - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         op_q  <= '0;
         ea_q  <= '0;
         acc   <= '0;
         bcnt  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (in_valid) begin
                  op_q  <= dec_op;
                  state <= ST_ADDR;
               end
            end
            ST_ADDR: begin
               if (!op_q.known) begin
                  state <= ST_IDLE;
               end else begin
                  ea_q  <= ea_in;
                  bcnt  <= '0;
                  state <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (mem_req_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  acc <= {acc[ACC_W-9:0], mem_rsp_data};
                  if (last_byte) begin
                     state <= ST_WB_DST;
                  end else begin
                     bcnt  <= bcnt + 1'b1;
                     state <= ST_REQ;
                  end
               end
            end
            ST_WB_DST:  state <= op_q.update ? ST_WB_BASE : ST_IDLE;
            ST_WB_BASE: state <= ST_IDLE;
            default:    state <= ST_IDLE;
         endcase
      end
   end

   if (XLEN > ADDR_W) begin : g_ea_pad
      assign ea_ext = {{(XLEN-ADDR_W){1'b0}}, ea_q};
   end else begin : g_ea_flat
      assign ea_ext = ea_q;
   end

   always_comb begin
      in_ready      = (state == ST_IDLE);
      mem_req_valid = (state == ST_REQ);
      mem_req_addr  = ea_q + ADDR_W'(bcnt);
      flag_unknown  = (state == ST_ADDR) && !op_q.known;
      wb_en         = (state == ST_WB_DST) || (state == ST_WB_BASE);
      wb_idx        = (state == ST_WB_BASE) ? op_q.ra : op_q.rt;
      wb_data       = (state == ST_WB_BASE) ? ea_ext
                                            : {{(XLEN-ACC_W){1'b0}}, acc};
      flag_bad_form = (state == ST_WB_DST) && op_q.update &&
                      ((op_q.ra == '0) || (op_q.ra == op_q.rt));
   end
endmodule

// File: rtl/half_zload_unit.sv
module half_zload_unit
   import hzl_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int XLEN    = 64,
   parameter int ADDR_W  = 32,
   parameter int NBYTES  = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [INSTR_W-1:0] in_instr,
   output logic [FLD_W-1:0]   rd_a_idx,
   input  logic [XLEN-1:0]    rd_a_data,
   output logic [FLD_W-1:0]   rd_b_idx,
   input  logic [XLEN-1:0]    rd_b_data,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [ADDR_W-1:0]  mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [7:0]         mem_rsp_data,
   output logic               wb_en,
   output logic [FLD_W-1:0]   wb_idx,
   output logic [XLEN-1:0]    wb_data,
   output logic               flag_bad_form,
   output logic               flag_unknown
);
   if (XLEN < ADDR_W) begin : g_chk_addr
      $error("half_zload_unit: ADDR_W wider than XLEN");
   end
   if (XLEN <= 8 * NBYTES) begin : g_chk_xlen
      $error("half_zload_unit: XLEN must exceed the loaded width");
   end
   if (NBYTES != 2) begin : g_chk_nbytes
      $error("half_zload_unit: only halfword loads are supported");
   end

   hzl_op_t           dec_op, op_q;
   logic [ADDR_W-1:0] ea;
   logic              base_zero;
   logic              unused_op;

   assign unused_op = op_q.known ^ (^op_q.rt);
   assign rd_a_idx  = op_q.ra;
   assign rd_b_idx  = op_q.rb;
   assign base_zero = !op_q.update && (op_q.ra == '0);

   hzl_decode #(.INSTR_W(INSTR_W)) u_dec (
      .instr (in_instr),
      .op    (dec_op)
   );

   hzl_agen #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_agen (
      .base_zero (base_zero),
      .indexed   (op_q.indexed),
      .disp      (op_q.disp),
      .a_data    (rd_a_data),
      .b_data    (rd_b_data),
      .ea        (ea)
   );

   hzl_seq #(.XLEN(XLEN), .ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_seq (
      .clk           (clk),
      .rst           (rst),
      .in_valid      (in_valid),
      .in_ready      (in_ready),
      .dec_op        (dec_op),
      .op_q          (op_q),
      .ea_in         (ea),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .wb_en         (wb_en),
      .wb_idx        (wb_idx),
      .wb_data       (wb_data),
      .flag_bad_form (flag_bad_form),
      .flag_unknown  (flag_unknown)
   );
endmodule

// File: rtl/hzl_checker.sv
module hzl_checker #(
   parameter int XLEN   = 64,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              in_ready,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              wb_en,
   input logic [XLEN-1:0]   wb_data,
   input logic              flag_bad_form,
   input logic              flag_unknown
);
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid || wb_en) |-> !in_ready);

   assert_wb_narrow_R6: assert property (@(posedge clk) disable iff (rst)
      wb_en |-> ((wb_data >> ADDR_W) == '0));

   assert_bad_with_wb_R8: assert property (@(posedge clk) disable iff (rst)
      flag_bad_form |-> wb_en);

   assert_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot0({flag_unknown, wb_en, mem_req_valid}));

   assert_unknown_pulse_R2: assert property (@(posedge clk) disable iff (rst)
      flag_unknown |=> (in_ready && !flag_unknown));

   assert_reset_idle_R10: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (in_ready && !mem_req_valid && !wb_en));
endmodule

bind half_zload_unit hzl_checker #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .in_ready      (in_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .wb_en         (wb_en),
   .wb_data       (wb_data),
   .flag_bad_form (flag_bad_form),
   .flag_unknown  (flag_unknown)
);

// File: tb/half_zload_unit_test.sv
`timescale 1ns/1ps
module half_zload_unit_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic        in_ready;
   logic [31:0] in_instr;
   logic [4:0]  rd_a_idx, rd_b_idx;
   logic [63:0] rd_a_data, rd_b_data;
   logic        mem_req_valid, mem_req_ready;
   logic [31:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [7:0]  mem_rsp_data;
   logic        wb_en;
   logic [4:0]  wb_idx;
   logic [63:0] wb_data;
   logic        flag_bad_form, flag_unknown;

   logic [63:0] regs [32];
   assign rd_a_data = regs[rd_a_idx];
   assign rd_b_data = regs[rd_b_idx];

   half_zload_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_instr(in_instr), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .wb_en(wb_en), .wb_idx(wb_idx),
      .wb_data(wb_data), .flag_bad_form(flag_bad_form),
      .flag_unknown(flag_unknown)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int          naddr, nwb, nunk, nbad;
   logic [31:0] addr_log [8];
   logic [4:0]  wbi_log [8];
   logic [63:0] wbd_log [8];
   logic        wbb_log [8];
   int          stall_cfg = 0, lat_cfg = 0;

   function automatic logic [7:0] mbyte(input logic [31:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ a[31:24] ^ 8'h3C;
   endfunction

   function automatic logic [31:0] enc_d(input int opc, input int rt, input int ra,
                                         input logic [15:0] d);
      return {6'(opc), 5'(rt), 5'(ra), d};
   endfunction

   function automatic logic [31:0] enc_x(input int rt, input int ra, input int rb,
                                         input int xo, input bit rc);
      return {6'd31, 5'(rt), 5'(ra), 5'(rb), 10'(xo), rc};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory responder: byte reads with configurable stall and latency
   initial begin
      logic [31:0] cur;
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 8'h00;
      forever begin
         @(negedge clk);
         if (mem_req_valid && !rst) begin
            repeat (stall_cfg) @(negedge clk);
            mem_req_ready = 1'b1;
            cur = mem_req_addr;
            if (naddr < 8) addr_log[naddr] = cur;
            naddr++;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (lat_cfg) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mbyte(cur);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   // write-back and flag monitor
   initial begin
      forever begin
         @(negedge clk);
         if (!rst) begin
            if (wb_en) begin
               if (nwb < 8) begin
                  wbi_log[nwb] = wb_idx;
                  wbd_log[nwb] = wb_data;
                  wbb_log[nwb] = flag_bad_form;
               end
               nwb++;
            end
            if (flag_unknown) nunk++;
            if (flag_bad_form) nbad++;
         end
      end
   end

   task automatic run_instr(input logic [31:0] ins, input int stall, input int lat);
      int cyc;
      logic [5:0]  opc;
      logic [9:0]  xo;
      logic [4:0]  rt, ra, rb;
      logic [15:0] d;
      bit known, upd, idx, bad;
      logic [63:0] base, offs, sum;
      logic [31:0] ea, ea1;
      logic [63:0] exp_val;

      @(negedge clk);
      naddr = 0; nwb = 0; nunk = 0; nbad = 0;
      stall_cfg = stall; lat_cfg = lat;
      in_valid = 1'b1;
      in_instr = ins;
      @(negedge clk);
      in_instr = enc_d(40, 1, 2, 16'h0004); // decoy held while busy
      chk(!in_ready, "R9 busy after accept", 64'(in_ready), 64'd0);
      cyc = 0;
      while (!in_ready && cyc < 200) begin
         @(negedge clk);
         cyc++;
      end
      in_valid = 1'b0;
      chk(cyc < 200, "R9 return to ready", 64'(cyc), 64'd0);

      opc = ins[31:26]; rt = ins[25:21]; ra = ins[20:16]; rb = ins[15:11];
      xo = ins[10:1]; d = ins[15:0];
      idx   = (opc == 6'd31) && (xo == 10'd279 || xo == 10'd311);
      upd   = (opc == 6'd41) || ((opc == 6'd31) && (xo == 10'd311));
      known = (opc == 6'd40) || (opc == 6'd41) || idx;
      base  = (!upd && ra == 5'd0) ? 64'd0 : regs[ra];
      offs  = idx ? regs[rb] : {{48{d[15]}}, d};
      sum   = base + offs;
      ea    = sum[31:0];
      ea1   = ea + 32'd1;
      exp_val = {48'd0, mbyte(ea), mbyte(ea1)};
      bad   = upd && (ra == 5'd0 || ra == rt);

      if (!known) begin
         chk(nunk == 1, "R2 unknown pulse", 64'(nunk), 64'd1);
         chk(naddr == 0, "R2 no request", 64'(naddr), 64'd0);
         chk(nwb == 0, "R2 no write-back", 64'(nwb), 64'd0);
      end else begin
         chk(nunk == 0, "R1 recognised", 64'(nunk), 64'd0);
         chk(naddr == 2, "R5 two requests", 64'(naddr), 64'd2);
         if (!upd && ra == 5'd0)
            chk(addr_log[0] == ea, "R3 literal zero base", 64'(addr_log[0]), 64'(ea));
         chk(addr_log[0] == ea, "R4 effective address", 64'(addr_log[0]), 64'(ea));
         chk(addr_log[1] == ea1, "R5 second byte address", 64'(addr_log[1]), 64'(ea1));
         chk(nwb == (upd ? 2 : 1), "R7 write-back count", 64'(nwb), upd ? 64'd2 : 64'd1);
         chk(wbi_log[0] == rt, "R1 destination field", 64'(wbi_log[0]), 64'(rt));
         chk(wbd_log[0] == exp_val, "R6 loaded value", wbd_log[0], exp_val);
         chk(wbb_log[0] == bad, "R8 bad form flag", 64'(wbb_log[0]), 64'(bad));
         chk(nbad == int'(bad), "R8 bad flag count", 64'(nbad), 64'(bad));
         if (upd && nwb >= 2) begin
            chk(wbi_log[1] == ra, "R7 base index", 64'(wbi_log[1]), 64'(ra));
            chk(wbd_log[1] == {32'd0, ea}, "R7 base value", wbd_log[1], {32'd0, ea});
         end
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) regs[i] = 64'h9E37_79B9_7F4A_7C15 * 64'(i + 1);
      rst = 1'b1; in_valid = 1'b0; in_instr = 32'h0;
      naddr = 0; nwb = 0; nunk = 0; nbad = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(in_ready == 1'b1, "R10 reset ready", 64'(in_ready), 64'd1);
      chk(mem_req_valid == 1'b0, "R10 reset no request", 64'(mem_req_valid), 64'd0);
      chk(wb_en == 1'b0 && flag_unknown == 1'b0 && flag_bad_form == 1'b0,
          "R10 reset quiet", 64'({wb_en, flag_unknown, flag_bad_form}), 64'd0);
      rst = 1'b0;

      // all A fields in all four forms
      for (int f = 0; f < 4; f++) begin
         for (int ra = 0; ra < 32; ra++) begin
            int rt = (ra * 7 + 3) % 32;
            int rb = (ra + 5) % 32;
            logic [15:0] d = 16'(ra * 1237) ^ 16'h8001;
            logic [31:0] w;
            case (f)
               0:       w = enc_d(40, rt, ra, d);
               1:       w = enc_d(41, rt, ra, d);
               2:       w = enc_x(rt, ra, rb, 279, 1'b0);
               default: w = enc_x(rt, ra, rb, 311, 1'b0);
            endcase
            run_instr(w, ra % 3, (ra / 3) % 3);
         end
      end

      // all destination fields, displacement form
      for (int rt = 0; rt < 32; rt++) run_instr(enc_d(40, rt, 4, 16'(rt * 3)), 0, 0);

      // A equals destination on update forms, and on a plain form
      run_instr(enc_d(41, 9, 9, 16'h0011), 2, 1);
      run_instr(enc_x(12, 12, 3, 311, 1'b0), 1, 2);
      run_instr(enc_d(40, 9, 9, 16'h0011), 0, 0);
      run_instr(enc_x(7, 0, 3, 311, 1'b0), 0, 1);

      // displacement extremes and wrap
      regs[5] = 64'hFFFF_FFFF_FFFF_FFFF;
      regs[6] = 64'h0000_0001_0000_0000;
      regs[8] = 64'h0000_0000_0000_1000;
      run_instr(enc_d(40, 1, 5, 16'h0000), 0, 0);   // EA=FFFFFFFF, wrap
      run_instr(enc_d(40, 1, 6, 16'h8000), 1, 0);   // negative disp
      run_instr(enc_d(41, 2, 8, 16'h7FFF), 0, 2);   // largest positive
      run_instr(enc_d(40, 2, 8, 16'hFFFF), 0, 0);   // minus one, odd
      run_instr(enc_x(3, 8, 5, 279, 1'b0), 0, 0);   // index of all ones
      run_instr(enc_x(3, 0, 6, 279, 1'b0), 0, 0);   // zero base, big index
      run_instr(enc_x(4, 5, 5, 311, 1'b0), 2, 2);   // wrap on update

      // bit 0 set on indexed forms is ignored
      run_instr(enc_x(10, 8, 4, 279, 1'b1), 0, 0);
      run_instr(enc_x(11, 8, 4, 311, 1'b1), 0, 0);

      // unrecognised words
      run_instr(enc_d(42, 1, 2, 16'h0002), 0, 0);
      run_instr(enc_d(39, 1, 2, 16'h0002), 0, 0);
      run_instr(enc_x(1, 2, 3, 278, 1'b0), 0, 0);
      run_instr(enc_x(1, 2, 3, 280, 1'b0), 0, 0);
      run_instr(enc_x(1, 2, 3, 312, 1'b0), 0, 0);
      run_instr(32'h0000_0000, 0, 0);

      // reset while a load is in flight
      @(negedge clk);
      stall_cfg = 0; lat_cfg = 3;
      in_valid = 1'b1; in_instr = enc_d(41, 3, 4, 16'h0002);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      nwb = 0;
      @(negedge clk);
      chk(in_ready == 1'b1, "R10 reset mid-load ready", 64'(in_ready), 64'd1);
      chk(mem_req_valid == 1'b0, "R10 reset mid-load request", 64'(mem_req_valid), 64'd0);
      repeat (10) @(negedge clk);
      chk(nwb == 0, "R10 no write after reset", 64'(nwb), 64'd0);
      lat_cfg = 0;
      repeat (4) @(negedge clk);
      run_instr(enc_d(40, 6, 8, 16'h0003), 0, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule